// File: doc/BRIEF.md
# Display suspend and rectangular memory fill engine

This block sits beside the display fetch path of a video memory controller. Software can put the display into a suspended state. While it is suspended, the screen read requests coming from the display fetch logic are held back and the video output is forced to black. The CPU then has the whole memory bandwidth to itself.

While the display is suspended, the block can also fill a rectangle of screen memory with one byte value. The rectangle is given by a start byte address, a width in bytes, a height in rows and a row stride in bytes. The engine walks the rectangle row by row and raises a write request for each byte. It moves to the next byte only after the memory arbiter grants the current write. Clearing suspend stops a running fill at once.

Register map: register writes use `reg_sel` and `reg_wdata`.
- Selector 0 is control. Bit 0 is suspend and bit 1 is start fill.
- Selectors 1 to 5 hold the start address, width, height, stride and fill value, in that order.

Top module: `vid_suspend_fill`

## Requirements
- R1: After reset, suspend is off and `busy`, `mem_wr_req` and `blank_o` are all 0.
- R2: `scan_req_o` follows `scan_req_i` while suspend is off and is 0 while suspend is on.
- R3: `blank_o` is 1 exactly while suspend is on. A control write (selector 0) sets suspend to `reg_wdata[0]` at the next clock.
- R4: A control write with bit 1 set and bit 0 clear is ignored as a fill command. No write request is raised and `busy` stays 0.
- R5: Every write request carries the fill value register (selector 5, low 8 bits) on `mem_wr_data`.
- R6: A fill writes the addresses `start + r*stride + c` for every row r below the height and every column c below the width, in increasing c within increasing r. Start is selector 1, width is selector 2, height is selector 3 and stride is selector 4.
- R7: While a write request is not granted, the request stays high and its address and data stay stable. The engine advances only on a clock where `mem_wr_gnt` is 1.
- R8: `busy` and `mem_wr_req` rise on the clock after an accepted start (bits 0 and 1 both set while not busy). They fall on the clock after the last byte is granted.
- R9: A control write that clears suspend during a fill drops `busy` and `mem_wr_req` at the next clock, and no further writes follow.
- R10: A start with a width or height of zero completes at once. `busy` never rises and no write is requested.
- R11: While `busy` is 1, start commands and writes to selectors 1 to 5 are ignored. A new start command does not restart the fill, and the running fill keeps its geometry and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | ADDR_W (16) | Register write data |
| scan_req_i | input | 1 | Screen read request from the display fetch logic |
| scan_req_o | output | 1 | Screen read request passed on to memory |
| blank_o | output | 1 | Force the video output to black |
| mem_wr_req | output | 1 | Fill write request |
| mem_wr_addr | output | ADDR_W (16) | Fill write byte address |
| mem_wr_data | output | DATA_W (8) | Fill write data |
| mem_wr_gnt | input | 1 | Grant for the current fill write |
| busy | output | 1 | Fill in progress |

## Verification
The hardest cases to reach from the ports are collisions at the clock edge where the last byte is granted. At that edge a new start, a geometry write or a suspend clear can land together with the completion, and the order of those effects decides what the engine does next. The stimulus drives the grant randomly, so that rows end on both stalled and granted cycles. It also issues register writes while a fill is running, and times a suspend clear in the middle of a rectangle. A behavioural queue of expected addresses is compared against the ports on every clock.

// File: rtl/vid_suspend_fill.sv
module vid_suspend_fill #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              scan_req_i,
  output logic              scan_req_o,
  output logic              blank_o,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_gnt,
  output logic              busy
);
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_BASE = 3'd1;
  localparam logic [2:0] SEL_WID  = 3'd2;
  localparam logic [2:0] SEL_HGT  = 3'd3;
  localparam logic [2:0] SEL_STR  = 3'd4;
  localparam logic [2:0] SEL_VAL  = 3'd5;

  logic              susp;
  logic [ADDR_W-1:0] base, stride, addr;
  logic [DIM_W-1:0]  wid, hgt, col, row;
  logic [DATA_W-1:0] val;

  wire wr_ctrl  = reg_we && (reg_sel == SEL_CTRL);
  wire abort    = wr_ctrl && !reg_wdata[0];
  wire start_ok = wr_ctrl && reg_wdata[0] && reg_wdata[1] && !busy && (wid != '0) && (hgt != '0);
  wire row_end  = (col == wid - 1'b1);
  wire last     = row_end && (row == hgt - 1'b1);

  assign scan_req_o  = scan_req_i && !susp;
  assign blank_o     = susp;
  assign mem_wr_req  = busy;
  assign mem_wr_addr = addr;
  assign mem_wr_data = val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp   <= 1'b0;
      busy   <= 1'b0;
      base   <= '0;
      stride <= '0;
      addr   <= '0;
      wid    <= '0;
      hgt    <= '0;
      col    <= '0;
      row    <= '0;
      val    <= '0;
    end else begin
      if (wr_ctrl) susp <= reg_wdata[0];
      if (reg_we && !busy) begin
        case (reg_sel)
          SEL_BASE: base   <= reg_wdata;
          SEL_WID:  wid    <= reg_wdata[DIM_W-1:0];
          SEL_HGT:  hgt    <= reg_wdata[DIM_W-1:0];
          SEL_STR:  stride <= reg_wdata;
          SEL_VAL:  val    <= reg_wdata[DATA_W-1:0];
          default: ;
        endcase
      end
      if (abort) begin
        busy <= 1'b0;
      end else if (start_ok) begin
        busy <= 1'b1;
        addr <= base;
        col  <= '0;
        row  <= '0;
      end else if (busy && mem_wr_gnt) begin
        if (last) begin
          busy <= 1'b0;
        end else if (row_end) begin
          col  <= '0;
          row  <= row + 1'b1;
          addr <= addr + stride - ADDR_W'(wid) + ADDR_W'(1);
        end else begin
          col  <= col + 1'b1;
          addr <= addr + ADDR_W'(1);
        end
      end
    end
  end

  // R7: a stalled request holds unless suspend is being cleared
  a_r7_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_gnt && !abort) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R4: writes only ever happen while the display is blanked
  a_r4_write_only_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> blank_o);

  // R9: clearing suspend ends the fill next clock
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R8: busy only falls after a grant or an abort
  a_r8_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mem_wr_gnt) || $past(abort)));

  // R2: no screen read passes while suspended
  a_r2_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> !scan_req_o);
endmodule

// File: tb/vid_suspend_fill_tb.sv
module vid_suspend_fill_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          scan_req_i = 1'b0;
  logic          mem_wr_gnt = 1'b0;
  logic          scan_req_o, blank_o, mem_wr_req, busy;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int checks = 0;
  int fails = 0;
  int pops = 0;
  int gnt_mode = 0;

  vid_suspend_fill dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scan_req_i(scan_req_i), .scan_req_o(scan_req_o), .blank_o(blank_o),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_gnt(mem_wr_gnt), .busy(busy));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  bit            m_susp;
  logic [AW-1:0] m_base, m_stride;
  int            m_w, m_h;
  logic [DW-1:0] m_val;
  logic [AW-1:0] q[$];

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      m_susp = 0; m_base = '0; m_stride = '0; m_w = 0; m_h = 0; m_val = '0;
      q.delete();
    end else begin
      was_busy = (q.size() != 0);
      if (was_busy && mem_wr_gnt) begin
        void'(q.pop_front());
        pops++;
      end
      if (reg_we && reg_sel == 3'd0) begin
        m_susp = reg_wdata[0];
        if (!reg_wdata[0]) q.delete();
        else if (reg_wdata[1] && !was_busy)
          for (int r = 0; r < m_h; r++)
            for (int c = 0; c < m_w; c++)
              q.push_back(AW'(m_base + AW'(r) * m_stride + AW'(c)));
      end else if (reg_we && !was_busy) begin
        case (reg_sel)
          3'd1: m_base = reg_wdata;
          3'd2: m_w = int'(reg_wdata[7:0]);
          3'd3: m_h = int'(reg_wdata[7:0]);
          3'd4: m_stride = reg_wdata;
          3'd5: m_val = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
    #1;
    if (rst_n) begin
      chk(busy == (q.size() != 0), "R8 busy", busy, q.size() != 0);
      chk(mem_wr_req == (q.size() != 0), "R7 req", mem_wr_req, q.size() != 0);
      if (q.size() != 0) begin
        chk(mem_wr_addr == q[0], "R6 addr", mem_wr_addr, q[0]);
        chk(mem_wr_data == m_val, "R5 data", mem_wr_data, m_val);
      end
      chk(blank_o == m_susp, "R3 blank", blank_o, m_susp);
      chk(scan_req_o == (scan_req_i && !m_susp), "R2 scan", scan_req_o, scan_req_i && !m_susp);
    end
  end

  always @(negedge clk) begin
    scan_req_i <= 1'($urandom_range(0, 1));
    case (gnt_mode)
      0: mem_wr_gnt <= 1'b0;
      1: mem_wr_gnt <= 1'b1;
      default: mem_wr_gnt <= ($urandom_range(0, 2) == 0);
    endcase
  end

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic geom(input int b, input int w, input int h, input int s, input int v);
    wr(3'd1, AW'(b)); wr(3'd2, AW'(w)); wr(3'd3, AW'(h)); wr(3'd4, AW'(s)); wr(3'd5, AW'(v));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && mem_wr_req == 0 && blank_o == 0, "R1 reset outputs", {busy, mem_wr_req, blank_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 R7 R5: fill under random grants
    gnt_mode = 2;
    geom(16'h0100, 3, 2, 8, 8'hA5);
    p0 = pops;
    wr(3'd0, 16'h3);
    wait_idle();
    chk(pops - p0 == 6, "R6 write count", pops - p0, 6);

    // R7: grant held low stalls the engine
    gnt_mode = 0;
    geom(16'h0200, 4, 3, 16, 8'h3C);
    wr(3'd0, 16'h3);
    repeat (10) @(negedge clk);
    #1 chk(mem_wr_addr == 16'h0200, "R7 stalled addr", mem_wr_addr, 16'h0200);
    // R11: geometry write and restart while busy ignored
    wr(3'd5, 16'h77);
    wr(3'd0, 16'h3);
    #1 chk(mem_wr_data == 8'h3C, "R11 value kept", mem_wr_data, 8'h3C);
    gnt_mode = 1;
    wait_idle();
    chk(pops - p0 == 18, "R6 second count", pops - p0, 18);

    // R4: start without suspend ignored
    gnt_mode = 2;
    p0 = pops;
    wr(3'd0, 16'h2);
    repeat (5) @(negedge clk);
    #1 chk(busy == 0 && pops == p0, "R4 ignored start", busy, 0);

    // R10: zero width and zero height
    geom(16'h0300, 0, 4, 8, 8'h11);
    wr(3'd0, 16'h3);
    repeat (3) @(negedge clk);
    #1 chk(busy == 0 && pops == p0, "R10 zero width", busy, 0);
    geom(16'h0300, 4, 0, 8, 8'h11);
    wr(3'd0, 16'h3);
    repeat (3) @(negedge clk);
    #1 chk(busy == 0 && pops == p0, "R10 zero height", busy, 0);

    // R9: abort mid fill
    geom(16'h0400, 8, 8, 32, 8'h5A);
    wr(3'd0, 16'h3);
    repeat (12) @(negedge clk);
    wr(3'd0, 16'h0);
    #1 chk(busy == 0 && mem_wr_req == 0, "R9 abort", busy, 0);
    p0 = pops;
    repeat (5) @(negedge clk);
    chk(pops == p0, "R9 no writes after abort", pops - p0, 0);

    // R6: wrapping stride, full grant
    gnt_mode = 1;
    geom(16'hFFF0, 5, 3, 7, 8'hC3);
    p0 = pops;
    wr(3'd0, 16'h3);
    wait_idle();
    chk(pops - p0 == 15, "R6 wrap count", pops - p0, 15);
    wr(3'd0, 16'h0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule